// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a multiplier that software drives through a small synchronous register bus. A processor stores the first operand at one of four operand-A addresses. Which of the four it uses selects the operation: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Storing the second operand starts the selected operation.

The 32-bit result, or the updated accumulator, is held in a low and a high result word. A third word, the extension word, holds the sign or the carry. Operands are 16 bits wide. A byte write stores an 8-bit operand, so the unit covers the 8x8, 8x16, 16x8 and 16x16 cases. The result registers can be written, so an accumulation can start from any value. The answer is ready to read on the first bus access after the second-operand write. Software needs no wait states and no polling.

Top module: `mac_periph`

## Requirements
- R1: The bus selects one 16-bit word with a 3-bit word index. Index 0 is the result low word, 1 the result high word, 2 the extension word and 3 operand B. Indices 4, 5, 6 and 7 are operand A for unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. A read with `bus_sel` high returns the addressed word; reading an operand index returns the stored, extended operand. `bus_rdata` is zero when `bus_sel` is low.
- R2: A write to indices 4 to 7 stores operand A and latches that index's operation. A write to operand B runs the most recently latched operation.
- R3: The result and extension words hold the new values at the first bus access after the clock edge that took the operand-B write.
- R4: Unsigned multiply gives the 32-bit unsigned product of A and B in the high:low result words, and the extension word reads 0x0000.
- R5: Signed multiply gives the two's-complement product. The extension word reads 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit high:low value, wrapping modulo 2^32. The extension word reads the carry out of that sum (0 or 1).
- R7: Signed accumulate adds the signed product to high:low, wrapping modulo 2^32. The extension word reads 0xFFFF when bit 31 of the new sum is 1 and 0x0000 otherwise.
- R8: A byte write (`bus_byte` high) to an operand uses only `bus_wdata[7:0]`. The value is sign-extended when the operation is signed and zero-extended when it is unsigned. For operand A, the operation is the one being written. For operand B, it is the one currently latched.
- R9: The result low and high words are writable, so the accumulator can be preloaded. A byte write to either word stores `bus_wdata[7:0]` with the upper byte cleared.
- R10: Writes to the extension word are ignored.
- R11: Synchronous active-high reset clears all words and latches unsigned multiply.
- R12: Operand A persists, so each further operand-B write repeats the latched operation with the same operand A. Result words change only on an operand-B write or a direct write to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | Byte write: only bits 7:0 are taken |
| bus_word | input | 3 | Word index (see R1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the index |

## Verification
Every write takes effect at the rising edge inside its access. Reads are combinational, so a value written at one edge can be read in the low half of the following cycle. The bench drives each access on a falling edge and samples read data one nanosecond later. It checks the result, high and extension words in the access straight after the operand-B write, with no idle cycle in between. This is the one-cycle latency of R3. Register checks in the RTL look exactly one edge after the triggering write.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        M_UMUL = 2'd0,
        M_SMUL = 2'd1,
        M_UACC = 2'd2,
        M_SACC = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        W_ACCLO = 3'd0,
        W_ACCHI = 3'd1,
        W_EXT   = 3'd2,
        W_OPB   = 3'd3,
        W_UMUL  = 3'd4,
        W_SMUL  = 3'd5,
        W_UACC  = 3'd6,
        W_SACC  = 3'd7
    } word_t;

    typedef struct packed {
        logic  opa;
        logic  opb;
        logic  acc_lo;
        logic  acc_hi;
        mode_t mode;
    } strobe_t;

    function automatic logic is_signed(mode_t m);
        return (m == M_SMUL) || (m == M_SACC);
    endfunction

    function automatic logic is_accum(mode_t m);
        return (m == M_UACC) || (m == M_SACC);
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic          sel,
    input  logic          wr,
    input  logic [2:0]    word,
    output strobe_t       st
);
    always_comb begin
        st      = '0;
        st.mode = M_UMUL;
        if (sel && wr) begin
            case (word_t'(word))
                W_ACCLO: st.acc_lo = 1'b1;
                W_ACCHI: st.acc_hi = 1'b1;
                W_OPB:   st.opb    = 1'b1;
                W_UMUL:  begin st.opa = 1'b1; st.mode = M_UMUL; end
                W_SMUL:  begin st.opa = 1'b1; st.mode = M_SMUL; end
                W_UACC:  begin st.opa = 1'b1; st.mode = M_UACC; end
                W_SACC:  begin st.opa = 1'b1; st.mode = M_SACC; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mac_operands.sv
module mac_operands
    import mac_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  mode_t             wr_mode,
    input  logic              byte_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output mode_t             mode
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_val, b_val;
    logic              a_sx, b_sx;

    assign a_sx = is_signed(wr_mode) & wdata[HALF_W-1];
    assign b_sx = is_signed(mode) & wdata[HALF_W-1];

    assign a_val = byte_wr ? {{HALF_W{a_sx}}, wdata[HALF_W-1:0]} : wdata;
    assign b_val = byte_wr ? {{HALF_W{b_sx}}, wdata[HALF_W-1:0]} : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
            mode <= M_UMUL;
        end else begin
            if (wr_a) begin
                op_a <= a_val;
                mode <= wr_mode;
            end
            if (wr_b) op_b <= b_val;
        end
    end

    // R8: unsigned byte operand B carries a clear upper half
    a_r8_opb_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (wr_b && byte_wr && !is_signed(mode)) |=> (op_b[DATA_W-1:HALF_W] == '0));

    // R2: the latched operation follows the operand-A address
    a_r2_mode_latch: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (mode == $past(wr_mode)));

    // R12: operand A holds without an operand-A write
    a_r12_opa_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_a |=> $stable(op_a));
endmodule

// File: rtl/mac_engine.sv
module mac_engine
    import mac_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  mode_t               mode,
    input  logic [2*DATA_W-1:0] acc_in,
    output logic [2*DATA_W-1:0] res,
    output logic [DATA_W-1:0]   ext
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0] sprod;
    logic        [PW-1:0] uprod;
    logic        [PW-1:0] prod;
    logic        [PW:0]   sum;

    assign sprod = $signed({{DATA_W{op_a[DATA_W-1]}}, op_a}) *
                   $signed({{DATA_W{op_b[DATA_W-1]}}, op_b});
    assign uprod = {{DATA_W{1'b0}}, op_a} * {{DATA_W{1'b0}}, op_b};
    assign prod  = is_signed(mode) ? sprod : uprod;
    assign sum   = {1'b0, acc_in} + {1'b0, prod};

    always_comb begin
        res = is_accum(mode) ? sum[PW-1:0] : prod;
        case (mode)
            M_UMUL:  ext = '0;
            M_SMUL:  ext = {DATA_W{prod[PW-1]}};
            M_UACC:  ext = {{(DATA_W-1){1'b0}}, sum[PW]};
            default: ext = {DATA_W{sum[PW-1]}};
        endcase
    end
endmodule

// File: rtl/mac_results.sv
module mac_results
    import mac_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                byte_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] res_in,
    input  logic [DATA_W-1:0]   ext_in,
    input  mode_t               mode,
    output logic [DATA_W-1:0]   acc_lo,
    output logic [DATA_W-1:0]   acc_hi,
    output logic [DATA_W-1:0]   ext
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] wval;
    assign wval = byte_wr ? {{HALF_W{1'b0}}, wdata[HALF_W-1:0]} : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_lo <= '0;
            acc_hi <= '0;
            ext    <= '0;
        end else if (trig) begin
            acc_lo <= res_in[DATA_W-1:0];
            acc_hi <= res_in[2*DATA_W-1:DATA_W];
            ext    <= ext_in;
        end else begin
            if (wr_lo) acc_lo <= wval;
            if (wr_hi) acc_hi <= wval;
        end
    end

    // R4: unsigned multiply leaves a zero extension word
    a_r4_umul_ext: assert property (@(posedge clk) disable iff (rst)
        (trig && mode == M_UMUL) |=> (ext == '0));

    // R5: signed multiply extension mirrors the product sign
    a_r5_smul_ext: assert property (@(posedge clk) disable iff (rst)
        (trig && mode == M_SMUL) |=>
            ((ext == '0 || ext == '1) && ext[0] == acc_hi[DATA_W-1]));

    // R6: unsigned accumulate extension is a single carry bit
    a_r6_uacc_carry: assert property (@(posedge clk) disable iff (rst)
        (trig && mode == M_UACC) |=> (ext[DATA_W-1:1] == '0));

    // R7: signed accumulate extension mirrors the sum sign
    a_r7_sacc_ext: assert property (@(posedge clk) disable iff (rst)
        (trig && mode == M_SACC) |=>
            ((ext == '0 || ext == '1) && ext[0] == acc_hi[DATA_W-1]));

    // R10: the extension word moves only on an operation
    a_r10_ext_hold: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(ext));

    // R12: result words hold without a trigger or direct write
    a_r12_lo_hold: assert property (@(posedge clk) disable iff (rst)
        (!trig && !wr_lo) |=> $stable(acc_lo));
    a_r12_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (!trig && !wr_hi) |=> $stable(acc_hi));

    // R9: byte preload clears the upper byte
    a_r9_byte_preload: assert property (@(posedge clk) disable iff (rst)
        (!trig && wr_lo && byte_wr) |=> (acc_lo[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [2:0]        bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    strobe_t             st;
    mode_t               mode;
    logic [DATA_W-1:0]   op_a, op_b, acc_lo, acc_hi, ext, ext_new;
    logic [2*DATA_W-1:0] res_new;

    mac_decode u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .word (bus_word),
        .st   (st)
    );

    mac_operands #(.DATA_W(DATA_W)) u_operands (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (st.opa),
        .wr_b    (st.opb),
        .wr_mode (st.mode),
        .byte_wr (bus_byte),
        .wdata   (bus_wdata),
        .op_a    (op_a),
        .op_b    (op_b),
        .mode    (mode)
    );

    // The engine sees the operand-B value being written so the
    // result registers load at the same edge as operand B.
    logic [DATA_W-1:0] b_live;
    localparam int HALF_W = DATA_W / 2;
    assign b_live = !st.opb ? op_b :
                    bus_byte ? {{HALF_W{is_signed(mode) & bus_wdata[HALF_W-1]}},
                                bus_wdata[HALF_W-1:0]} : bus_wdata;

    mac_engine #(.DATA_W(DATA_W)) u_engine (
        .op_a   (op_a),
        .op_b   (b_live),
        .mode   (mode),
        .acc_in ({acc_hi, acc_lo}),
        .res    (res_new),
        .ext    (ext_new)
    );

    mac_results #(.DATA_W(DATA_W)) u_results (
        .clk     (clk),
        .rst     (rst),
        .trig    (st.opb),
        .wr_lo   (st.acc_lo),
        .wr_hi   (st.acc_hi),
        .byte_wr (bus_byte),
        .wdata   (bus_wdata),
        .res_in  (res_new),
        .ext_in  (ext_new),
        .mode    (mode),
        .acc_lo  (acc_lo),
        .acc_hi  (acc_hi),
        .ext     (ext)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (word_t'(bus_word))
                W_ACCLO: bus_rdata = acc_lo;
                W_ACCHI: bus_rdata = acc_hi;
                W_EXT:   bus_rdata = ext;
                W_OPB:   bus_rdata = op_b;
                default: bus_rdata = op_a;
            endcase
        end
    end

    // R1: an idle bus reads as zero
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/test_mac_periph.sv
`timescale 1ns/1ps
module test_mac_periph;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [2:0] I_LO = 3'd0, I_HI = 3'd1, I_EXT = 3'd2, I_OPB = 3'd3;

    always #2.5 clk = ~clk;

    mac_periph i_mac_periph (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // {op code (bit0 signed, bit1 accumulate), A, B, accumulator preload}
    localparam logic [65:0] VEC [0:11] = '{
        {2'd0, 16'hFFFF, 16'hFFFF, 32'h0000_0000},
        {2'd0, 16'h1234, 16'h0010, 32'h0000_0000},
        {2'd1, 16'hFFFE, 16'h0003, 32'h0000_0000},
        {2'd1, 16'h8000, 16'h8000, 32'h0000_0000},
        {2'd1, 16'h7FFF, 16'h8000, 32'h0000_0000},
        {2'd2, 16'h0001, 16'h0001, 32'hFFFF_FFFF},
        {2'd2, 16'hFFFF, 16'hFFFF, 32'h0001_FFFF},
        {2'd2, 16'h0100, 16'h0100, 32'h1234_5678},
        {2'd3, 16'hFFFF, 16'h0001, 32'h0000_0000},
        {2'd3, 16'h0002, 16'h0003, 32'hFFFF_FFFA},
        {2'd3, 16'h8000, 16'h7FFF, 32'h8000_0000},
        {2'd3, 16'h7FFF, 16'h7FFF, 32'h7FFF_FFFF}
    };

    function automatic logic [47:0] model(logic [1:0] m, logic [15:0] a,
                                          logic [15:0] b, logic [31:0] acc);
        logic [31:0] p, r;
        logic [15:0] e;
        logic [32:0] s;
        int          sa, sb;
        longint      ua, ub;
        sa = $signed(a); sb = $signed(b);
        ua = a; ub = b;
        if (m[0]) p = 32'(sa * sb);
        else      p = 32'(ua * ub);
        if (!m[1]) begin
            r = p;
            e = m[0] ? {16{p[31]}} : 16'h0000;
        end else if (!m[0]) begin
            s = {1'b0, acc} + {1'b0, p};
            r = s[31:0];
            e = {15'b0, s[32]};
        end else begin
            r = acc + p;
            e = {16{r[31]}};
        end
        return {e, r};
    endfunction

    task automatic wr(input logic [2:0] w, input logic [15:0] d, input logic b);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_byte = b; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input logic [1:0] m, input logic [15:0] a,
                       input logic [15:0] b, input logic [31:0] acc, input string req);
        logic [47:0] e;
        logic [15:0] v;
        if (m[1]) begin
            wr(I_LO, acc[15:0], 1'b0);
            wr(I_HI, acc[31:16], 1'b0);
        end
        wr(3'd4 + 3'(m), a, 1'b0);
        wr(I_OPB, b, 1'b0);
        e = model(m, a, b, acc);
        rd(I_LO, v);  chk(req, v, e[15:0]);
        rd(I_HI, v);  chk(req, v, e[31:16]);
        rd(I_EXT, v); chk(req, v, e[47:32]);
    endtask

    function automatic string tag(logic [1:0] m);
        case (m)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: every word reads zero after reset
        for (int w = 0; w < 8; w++) begin
            rd(3'(w), v);
            chk("R11 reset", v, 16'h0000);
        end
        // R11/R8: after reset unsigned multiply is latched, so byte B zero-extends
        wr(I_OPB, 16'h5580, 1'b1);
        rd(I_OPB, v); chk("R11 R8 default unsigned", v, 16'h0080);
        // R1: idle bus returns zero
        bus_sel = 1'b0; #1; chk("R1 idle", bus_rdata, 16'h0000);

        // Table of vectors (R2, R3, R4..R7)
        for (int i = 0; i < 12; i++)
            run(VEC[i][65:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], tag(VEC[i][65:64]));

        // Random operands over every operation
        for (int i = 0; i < 48; i++) begin
            logic [1:0] m;
            m = 2'(i % 4);
            run(m, 16'($urandom), 16'($urandom), $urandom, tag(m));
        end

        // R8: signed byte operands sign-extend
        wr(3'd5, 16'h1280, 1'b1);
        rd(3'd5, v); chk("R8 signed A", v, 16'hFF80);
        wr(I_OPB, 16'h3402, 1'b1);
        rd(I_OPB, v); chk("R8 signed B", v, 16'h0002);
        rd(I_LO, v);  chk("R8 R5 lo", v, 16'hFF00);
        rd(I_HI, v);  chk("R8 R5 hi", v, 16'hFFFF);
        rd(I_EXT, v); chk("R8 R5 ext", v, 16'hFFFF);
        // R8: unsigned byte operands zero-extend
        wr(3'd4, 16'h1280, 1'b1);
        rd(3'd4, v); chk("R8 unsigned A", v, 16'h0080);
        wr(I_OPB, 16'hAAFE, 1'b1);
        rd(I_OPB, v); chk("R8 unsigned B", v, 16'h00FE);
        rd(I_LO, v);  chk("R8 R4 lo", v, 16'h7F00);
        rd(I_EXT, v); chk("R8 R4 ext", v, 16'h0000);

        // R10: writes to the extension word are ignored
        wr(3'd5, 16'hFFFF, 1'b0);
        wr(I_OPB, 16'h0001, 1'b0);
        wr(I_EXT, 16'h1234, 1'b0);
        rd(I_EXT, v); chk("R10 ext unchanged", v, 16'hFFFF);
        rd(I_LO, v);  chk("R10 lo unchanged", v, 16'hFFFF);

        // R9: byte preload clears the upper byte
        wr(I_LO, 16'hBEEF, 1'b1);
        rd(I_LO, v); chk("R9 byte lo", v, 16'h00EF);
        wr(I_HI, 16'hCAFE, 1'b1);
        rd(I_HI, v); chk("R9 byte hi", v, 16'h00FE);

        // R12: repeated operand-B writes reuse operand A
        wr(I_LO, 16'h0000, 1'b0);
        wr(I_HI, 16'h0000, 1'b0);
        wr(3'd6, 16'h0003, 1'b0);
        wr(I_OPB, 16'h0005, 1'b0);
        rd(I_LO, v); chk("R12 first", v, 16'd15);
        wr(I_OPB, 16'h0005, 1'b0);
        rd(I_LO, v); chk("R12 second", v, 16'd30);
        rd(I_EXT, v); chk("R12 R6 ext", v, 16'h0000);
        // R12: a read has no side effect
        rd(I_OPB, v); rd(I_LO, v); chk("R12 read only", v, 16'd30);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule